// File: doc/BRIEF.md
# DRAM Bank Decode and Strobe Sequencer

This block turns memory read and write cycles on a 20-bit bus into the control strobes of a DRAM array of up to three banks. The top three address bits are compared against one of four selectable memory maps. The result chooses which bank's row strobe fires, or none if the address is outside the map. A small sequencer then steps a decoded access through three phases on successive clock edges. The row strobe comes first, then the row/column address switch, then the column strobe. Everything is released on the edge after the bus strobe goes away.

Refresh cycles are marked by a refresh indication that arrives together with a bus strobe. A refresh fires all three row strobes at once and leaves the column strobe, the address switch and the data buffer enable idle, so only the row half of the address reaches the DRAM. The data buffer direction follows the kind of access. The top bit of the multiplexed address is passed out as it is, and the surrounding logic decides how to use it, because the device size of the lower banks is not known here.

Top module: `dram_strobe_seq`

## Requirements
- R1: While `rst` is high at a clock edge, every row strobe and the column strobe go high (inactive), `mux` goes to 0, `buf_en_n` goes high and `buf_dir` goes to 0.
- R2: With `map_sel`=0, an access with A19-A17=000 drives row strobe 0 (`ras_n[0]` low). Every other A19-A17 value is outside the map.
- R3: With `map_sel`=1, A19-A17=000 selects bank 0 and A19-A17=001 selects bank 1. Every other value is outside the map.
- R4: With `map_sel`=2, A19-A17 values 000, 001 and 010 select banks 0, 1 and 2. Every other value is outside the map.
- R5: With `map_sel`=3, A19-A18=00 selects bank 0 and A19-A18=01 selects bank 1. A19-A18 of 10 or 11 is outside the map.
- R6: An access outside the selected map asserts no row strobe, no column strobe and no `mux`, and keeps `buf_en_n` high.
- R7: For a decoded access first seen at clock edge k, the bank's row strobe goes low after edge k, `mux` goes to 1 after edge k+1, and `cas_n` goes low after edge k+2. These signals then hold for as long as the bus strobe stays low.
- R8: `dram_addr` equals A8-A0 while `mux` is 0 and A17-A9 while `mux` is 1. Bit 8 is passed out as it is, without any bank-size handling.
- R9: If both bus strobes are high at a clock edge, all strobes are inactive, `mux` is 0 and `buf_en_n` is high after that edge, whatever phase the sequence was in.
- R10: A cycle that starts with `refresh` high and a bus strobe low drives all three row strobes low after the first edge. `cas_n` stays high, `mux` stays 0 and `buf_en_n` stays high. This holds even if the address also decodes. `refresh` takes priority.
- R11: During a decoded access, `buf_en_n` is low and `buf_dir` is 1 for a read (`mem_rd_n` low) or 0 for a write (`mem_wr_n` low).
- R12: The bank is captured at the start of an access. Changing the address during the access does not move the row strobe to another bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 20 | Bus address A19-A0 |
| mem_rd_n | input | 1 | Memory read strobe, active low |
| mem_wr_n | input | 1 | Memory write strobe, active low |
| refresh | input | 1 | Marks the current strobe as a refresh cycle |
| map_sel | input | 2 | Memory map select (0 to 3) |
| ras_n | output | 3 | Row strobes for banks 2..0, active low |
| cas_n | output | 1 | Column strobe, active low |
| mux | output | 1 | 1 = column half of the address on `dram_addr` |
| buf_dir | output | 1 | Data buffer direction: 1 toward bus (read), 0 toward DRAM |
| buf_en_n | output | 1 | Data buffer enable, active low |
| dram_addr | output | 9 | Multiplexed DRAM address |

## Verification
A refresh indication and an ordinary in-map access can start on the same edge, because refresh is signalled alongside a normal bus strobe. The bench provokes this by raising `refresh` together with a read whose address decodes to bank 0 under the active map. It judges the outcome over the following cycles: all three row strobes must be low, and the column strobe, `mux` and the buffer enable must stay idle. The address lines must carry only the row half of the address until the strobe is released.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ROW  = 3'd1,
      ST_MUX  = 3'd2,
      ST_COL  = 3'd3,
      ST_REF  = 3'd4
   } seq_state_t;

   localparam int unsigned MAP_SEL_W = 2;

endpackage

// File: rtl/dram_bank_decode.sv
module dram_bank_decode #(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned NBANK  = 3,
   localparam int unsigned BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        map_sel,
   output logic              hit,
   output logic [BANK_W-1:0] bank
);
   logic [2:0] seg;

   assign seg = addr[ADDR_W-1 -: 3];

   always_comb begin
      hit  = 1'b0;
      bank = '0;
      unique case (map_sel)
         2'd0: begin
            hit = (seg == 3'd0);
         end
         2'd1: begin
            hit  = (seg <= 3'd1);
            bank = BANK_W'(seg[0]);
         end
         2'd2: begin
            hit  = (seg <= 3'd2);
            bank = BANK_W'(seg[1:0]);
         end
         default: begin
            hit  = ~seg[2];
            bank = BANK_W'(seg[1]);
         end
      endcase
   end

endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
   import dram_seq_pkg::*;
#(
   parameter int unsigned NBANK = 3,
   localparam int unsigned BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              strobe,
   input  logic              is_read,
   input  logic              refresh,
   input  logic              hit,
   input  logic [BANK_W-1:0] bank_in,
   output logic              acc_act,
   output logic              ref_act,
   output logic              mux_act,
   output logic              col_act,
   output logic              rd_q,
   output logic [BANK_W-1:0] bank_q
);
   seq_state_t state, nxt;

   always_comb begin
      nxt = state;
      if (!strobe) begin
         nxt = ST_IDLE;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (refresh)  nxt = ST_REF;
               else if (hit) nxt = ST_ROW;
            end
            ST_ROW:  nxt = ST_MUX;
            ST_MUX:  nxt = ST_COL;
            ST_COL:  nxt = ST_COL;
            ST_REF:  nxt = ST_REF;
            default: nxt = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= ST_IDLE;
         rd_q   <= 1'b0;
         bank_q <= '0;
      end else begin
         state <= nxt;
         if (state == ST_IDLE && nxt == ST_ROW) begin
            bank_q <= bank_in;
            rd_q   <= is_read;
         end else if (nxt == ST_IDLE || nxt == ST_REF) begin
            rd_q   <= 1'b0;
         end
      end
   end

   assign acc_act = (state == ST_ROW) || (state == ST_MUX) || (state == ST_COL);
   assign ref_act = (state == ST_REF);
   assign mux_act = (state == ST_MUX) || (state == ST_COL);
   assign col_act = (state == ST_COL);

   // R7
   mux_follows_row_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(mux_act) |-> $past(acc_act));

   // R7
   col_follows_mux_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(col_act) |-> $past(mux_act));

   // R12
   bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (acc_act && $past(acc_act)) |-> $stable(bank_q));

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned MA_W   = 9
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              sel_col,
   output logic [MA_W-1:0]   ma
);
   logic [MA_W-1:0] row_half, col_half;

   assign row_half = addr[MA_W-1:0];
   assign col_half = addr[2*MA_W-1:MA_W];
   assign ma       = sel_col ? col_half : row_half;

endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
   import dram_seq_pkg::*;
#(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned MA_W   = 9,
   parameter int unsigned NBANK  = 3,
   localparam int unsigned BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              mem_rd_n,
   input  logic              mem_wr_n,
   input  logic              refresh,
   input  logic [1:0]        map_sel,
   output logic [NBANK-1:0]  ras_n,
   output logic              cas_n,
   output logic              mux,
   output logic              buf_dir,
   output logic              buf_en_n,
   output logic [MA_W-1:0]   dram_addr
);
   generate
      if (ADDR_W < 2*MA_W) begin : g_bad_width
         $error("ADDR_W must cover both halves of the DRAM address");
      end
      if (NBANK != 3) begin : g_bad_banks
         $error("memory maps are defined for exactly three banks");
      end
      if (ADDR_W < 3) begin : g_bad_seg
         $error("ADDR_W too small for bank segment decode");
      end
   endgenerate

   logic              strobe, is_read, hit;
   logic [BANK_W-1:0] bank_dec, bank_q;
   logic              acc_act, ref_act, mux_act, col_act, rd_q;

   assign strobe  = ~mem_rd_n | ~mem_wr_n;
   assign is_read = ~mem_rd_n;

   dram_bank_decode #(.ADDR_W(ADDR_W), .NBANK(NBANK)) u_dec (
      .addr    (bus_addr),
      .map_sel (map_sel),
      .hit     (hit),
      .bank    (bank_dec)
   );

   dram_seq_fsm #(.NBANK(NBANK)) u_fsm (
      .clk     (clk),
      .rst     (rst),
      .strobe  (strobe),
      .is_read (is_read),
      .refresh (refresh),
      .hit     (hit),
      .bank_in (bank_dec),
      .acc_act (acc_act),
      .ref_act (ref_act),
      .mux_act (mux_act),
      .col_act (col_act),
      .rd_q    (rd_q),
      .bank_q  (bank_q)
   );

   dram_addr_mux #(.ADDR_W(ADDR_W), .MA_W(MA_W)) u_amux (
      .addr    (bus_addr),
      .sel_col (mux_act),
      .ma      (dram_addr)
   );

   generate
      for (genvar g = 0; g < NBANK; g++) begin : g_ras
         assign ras_n[g] = ~(ref_act | (acc_act && (bank_q == BANK_W'(g))));
      end
   endgenerate

   assign cas_n    = ~col_act;
   assign mux      = mux_act;
   assign buf_en_n = ~acc_act;
   assign buf_dir  = rd_q;

   // R2
   ras_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      !(&(~ras_n)) |-> $onehot0(~ras_n));

   // R7
   cas_needs_mux_chk: assert property (@(posedge clk) disable iff (rst)
      !cas_n |-> (mux && (ras_n != {NBANK{1'b1}})));

   // R10
   refresh_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (&(~ras_n)) |-> (cas_n && !mux && buf_en_n));

   // R9
   release_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (mem_rd_n && mem_wr_n) |=> ((ras_n == {NBANK{1'b1}}) && cas_n && !mux && buf_en_n));

   // R11
   buf_en_match_chk: assert property (@(posedge clk) disable iff (rst)
      !buf_en_n |-> ($countones(~ras_n) == 1));

endmodule

// File: tb/sim_dram_strobe_seq.sv
module sim_dram_strobe_seq;
   logic        clk = 1'b0;
   logic        rst;
   logic [19:0] bus_addr;
   logic        mem_rd_n, mem_wr_n, refresh;
   logic [1:0]  map_sel;
   logic [2:0]  ras_n;
   logic        cas_n, mux, buf_dir, buf_en_n;
   logic [8:0]  dram_addr;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   dram_strobe_seq u0 (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .mem_rd_n(mem_rd_n),
      .mem_wr_n(mem_wr_n), .refresh(refresh), .map_sel(map_sel),
      .ras_n(ras_n), .cas_n(cas_n), .mux(mux), .buf_dir(buf_dir),
      .buf_en_n(buf_en_n), .dram_addr(dram_addr)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic idle_check(input string req);
      chk(req, "ras_n", {29'd0, ras_n}, 32'h7);
      chk(req, "cas_n", {31'd0, cas_n}, 32'h1);
      chk(req, "mux", {31'd0, mux}, 32'h0);
      chk(req, "buf_en_n", {31'd0, buf_en_n}, 32'h1);
   endtask

   // bank < 0 means outside the map
   task automatic run_access(input string req, input logic [1:0] cfg,
                             input logic [19:0] a, input bit rd, input int bank);
      logic [2:0] exp_ras;
      @(negedge clk);
      map_sel = cfg; bus_addr = a; mem_rd_n = !rd; mem_wr_n = rd;
      @(negedge clk);
      exp_ras = (bank < 0) ? 3'b111 : ~(3'b001 << bank);
      chk(req, "ras_n row phase", {29'd0, ras_n}, {29'd0, exp_ras});
      chk("R7", "mux row phase", {31'd0, mux}, 32'h0);
      chk("R8", "row address", {23'd0, dram_addr}, {23'd0, a[8:0]});
      if (bank < 0) begin
         chk("R6", "buf_en_n miss", {31'd0, buf_en_n}, 32'h1);
         @(negedge clk);
         chk("R6", "mux miss", {31'd0, mux}, 32'h0);
         chk("R6", "cas_n miss", {31'd0, cas_n}, 32'h1);
      end else begin
         chk("R11", "buf_en_n", {31'd0, buf_en_n}, 32'h0);
         chk("R11", "buf_dir", {31'd0, buf_dir}, {31'd0, rd});
         @(negedge clk);
         chk("R7", "mux phase", {31'd0, mux}, 32'h1);
         chk("R7", "cas_n before col", {31'd0, cas_n}, 32'h1);
         chk("R8", "column address", {23'd0, dram_addr}, {23'd0, a[17:9]});
         @(negedge clk);
         chk("R7", "cas_n col phase", {31'd0, cas_n}, 32'h0);
         chk(req, "ras_n held", {29'd0, ras_n}, {29'd0, exp_ras});
      end
      mem_rd_n = 1'b1; mem_wr_n = 1'b1;
      @(negedge clk);
      idle_check("R9");
   endtask

   task automatic test_reset();
      rst = 1'b1; bus_addr = '0; mem_rd_n = 1'b1; mem_wr_n = 1'b1;
      refresh = 1'b0; map_sel = 2'd0;
      repeat (3) @(negedge clk);
      idle_check("R1");
      chk("R1", "buf_dir", {31'd0, buf_dir}, 32'h0);
      rst = 1'b0;
   endtask

   task automatic test_refresh_collision();
      @(negedge clk);
      map_sel = 2'd0; bus_addr = 20'h0_0155; refresh = 1'b1; mem_rd_n = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R10", "ras_n refresh", {29'd0, ras_n}, 32'h0);
         chk("R10", "cas_n refresh", {31'd0, cas_n}, 32'h1);
         chk("R10", "mux refresh", {31'd0, mux}, 32'h0);
         chk("R10", "buf_en_n refresh", {31'd0, buf_en_n}, 32'h1);
         chk("R10", "addr refresh", {23'd0, dram_addr}, 32'h155);
      end
      mem_rd_n = 1'b1; refresh = 1'b0;
      @(negedge clk);
      idle_check("R9");
   endtask

   task automatic test_early_release();
      @(negedge clk);
      map_sel = 2'd2; bus_addr = 20'h4_0000; mem_rd_n = 1'b0;
      @(negedge clk);
      chk("R4", "ras_n bank2", {29'd0, ras_n}, 32'h3);
      mem_rd_n = 1'b1;
      @(negedge clk);
      idle_check("R9");
   endtask

   task automatic test_bank_latch();
      @(negedge clk);
      map_sel = 2'd1; bus_addr = 20'h0_0010; mem_wr_n = 1'b0;
      @(negedge clk);
      bus_addr = 20'h2_0010;
      @(negedge clk);
      chk("R12", "ras_n after addr change", {29'd0, ras_n}, 32'h6);
      @(negedge clk);
      chk("R12", "ras_n still bank0", {29'd0, ras_n}, 32'h6);
      chk("R11", "buf_dir write", {31'd0, buf_dir}, 32'h0);
      mem_wr_n = 1'b1;
      @(negedge clk);
      idle_check("R9");
   endtask

   initial begin
      #(20 * 20000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      test_reset();
      run_access("R2", 2'd0, 20'h0_1234, 1'b1, 0);
      run_access("R2", 2'd0, 20'h2_0000, 1'b1, -1);
      run_access("R3", 2'd1, 20'h3_5A5A, 1'b1, 1);
      run_access("R3", 2'd1, 20'h4_0000, 1'b1, -1);
      run_access("R4", 2'd2, 20'h5_ABCD, 1'b0, 2);
      run_access("R4", 2'd2, 20'h6_0000, 1'b1, -1);
      run_access("R5", 2'd3, 20'h4_1FF0, 1'b1, 1);
      run_access("R5", 2'd3, 20'h3_FFFF, 1'b0, 0);
      run_access("R5", 2'd3, 20'h8_0000, 1'b1, -1);
      run_access("R11", 2'd0, 20'h1_0F0F, 1'b0, 0);
      test_refresh_collision();
      test_early_release();
      test_bank_latch();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule